// File: doc/BRIEF.md
# Home-Node Invalidation Directory Controller

This block sits at the home node of a distributed-memory multiprocessor. It holds the coherence directory for the memory blocks that live at that node. For each block it keeps a coherence state, a bit vector of the nodes that hold a cached copy, and the ID of the single writer when the block is dirty. Requests arrive on one valid/ready channel. Each request carries the requesting node ID, the block index, and a flag for read or read-exclusive. The controller handles one request at a time. Any other request is back-pressured until the current one has sent its reply.

A read-exclusive request sends one point-to-point invalidation to each remote node that holds a copy, one after another. The controller then grants ownership at once. The grant carries the number of invalidations that were sent. It does not wait for the acknowledgments: the requester counts those itself, as a relaxed consistency model allows. Remote nodes return their invalidation acknowledgments through the home. There a one-entry relay stage passes each one on toward the requester named in it. A read to a dirty block is forwarded to the current writer. The block then becomes shared by the writer and the reader.

The controller has five states:
- ST_IDLE accepts a request.
- ST_LOOKUP reads and rewrites the directory entry.
- ST_INVAL issues invalidations.
- ST_FORWARD sends the forwarded read.
- ST_REPLY returns the response.

The transitions are:
- IDLE→LOOKUP when a request is accepted.
- LOOKUP→INVAL when remote copies must be removed.
- LOOKUP→FORWARD on a read to a block that another node holds dirty.
- LOOKUP→REPLY otherwise.
- INVAL→REPLY when the last invalidation is accepted.
- FORWARD→REPLY when the forward is accepted.
- REPLY→IDLE when the response is accepted.

Top module: `home_dir`

## Requirements
- R1: After reset every block is Uncached, `req_ready` is 1 and no invalidation, forward, response or relayed acknowledgment is valid.
- R2: A read (`req_excl`=0) to an Uncached or Shared block gives one response with `rsp_excl`=0 and `rsp_acks`=0. No invalidation and no forward is sent, and the requester is added to the block's sharers.
- R3: A read-exclusive (`req_excl`=1) to a Shared block sends one invalidation to each sharer other than the requester, in ascending node ID order. Each invalidation carries the requester in `inv_orig` and the block in `inv_addr`, and none is sent to the requester.
- R4: The response to a read-exclusive has `rsp_excl`=1 and `rsp_acks` equal to the number of invalidations sent. It is issued only after the last invalidation has been accepted and does not wait for any acknowledgment.
- R5: A read-exclusive to an Uncached block is granted with `rsp_acks`=0, and the block becomes Dirty owned by the requester.
- R6: A read-exclusive to a block that another node holds Dirty sends exactly one invalidation, to that owner, and is granted with `rsp_acks`=1. The requester becomes the new owner.
- R7: A read to a block that another node holds Dirty sends one forward with `fwd_owner` set to the owner and `fwd_orig` set to the requester, then a response with `rsp_excl`=0 and `rsp_acks`=0. The block becomes Shared by exactly those two nodes.
- R8: Any request from the current owner of a Dirty block is answered with `rsp_acks`=0 and `rsp_excl` equal to the request flag. It sends no invalidation or forward and leaves the entry unchanged.
- R9: Only one transaction is in flight. `req_ready` is 0 from the cycle after a request is accepted until the response is accepted, and at most one of `inv_valid`, `fwd_valid` and `rsp_valid` is 1.
- R10: An acknowledgment accepted on the input channel appears on `ack_out_*` in the next cycle with the same destination and block, held until accepted. Acknowledgments leave in arrival order, and `ack_in_ready` is 1 whenever the relay stage is empty or being drained.
- R11: While an invalidation or response is valid and not accepted, its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_excl | input | 1 | 1 = read-exclusive, 0 = read |
| req_node | input | NODE_W | Requesting node ID |
| req_addr | input | ADDR_W | Block index |
| inv_valid | output | 1 | Invalidation message present |
| inv_ready | input | 1 | Network accepts invalidation |
| inv_node | output | NODE_W | Node to invalidate |
| inv_orig | output | NODE_W | Node the acknowledgment must reach |
| inv_addr | output | ADDR_W | Block to invalidate |
| fwd_valid | output | 1 | Forwarded read present |
| fwd_ready | input | 1 | Network accepts forward |
| fwd_owner | output | NODE_W | Current dirty owner |
| fwd_orig | output | NODE_W | Reading node |
| fwd_addr | output | ADDR_W | Block forwarded |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester accepts response |
| rsp_node | output | NODE_W | Node the response goes to |
| rsp_addr | output | ADDR_W | Block answered |
| rsp_excl | output | 1 | 1 = exclusive grant |
| rsp_acks | output | NODE_W | Acknowledgments the requester must collect |
| ack_in_valid | input | 1 | Incoming invalidation acknowledgment |
| ack_in_ready | output | 1 | Relay can take it |
| ack_in_dest | input | NODE_W | Originating node to notify |
| ack_in_addr | input | ADDR_W | Block acknowledged |
| ack_out_valid | output | 1 | Relayed acknowledgment present |
| ack_out_ready | input | 1 | Network accepts relayed acknowledgment |
| ack_out_dest | output | NODE_W | Originating node to notify |
| ack_out_addr | output | ADDR_W | Block acknowledged |

## Verification
The properties assume that the network and the requester follow valid/ready rules. That means once the block raises a valid, the other side eventually accepts it. They also assume that `req_node` is below NODES. The ascending-order and remote-only checks depend on the requester never being listed as its own victim. The bench keeps within these assumptions by driving legal node IDs only and by stalling each ready on a fixed pattern that always releases within two cycles. It presents a new request only after the previous response has been accepted.

// File: rtl/hd_pkg.sv
package hd_pkg;

    typedef enum logic [1:0] {
        BLK_UNCACHED = 2'd0,
        BLK_SHARED   = 2'd1,
        BLK_DIRTY    = 2'd2
    } blk_state_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOOKUP  = 3'd1,
        ST_INVAL   = 3'd2,
        ST_FORWARD = 3'd3,
        ST_REPLY   = 3'd4
    } ctl_state_e;

endpackage

// File: rtl/hd_dir_store.sv
module hd_dir_store
    import hd_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    localparam int NODE_W = $clog2(NODES),
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output blk_state_e        rd_state,
    output logic [NODE_W-1:0] rd_owner,
    output logic [NODES-1:0]  rd_sharers,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  blk_state_e        wr_state,
    input  logic [NODE_W-1:0] wr_owner,
    input  logic [NODES-1:0]  wr_sharers
);

    blk_state_e        st_q  [BLOCKS];
    logic [NODE_W-1:0] own_q [BLOCKS];
    logic [NODES-1:0]  sh_q  [BLOCKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                st_q[b]  <= BLK_UNCACHED;
                own_q[b] <= '0;
                sh_q[b]  <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_addr]  <= wr_state;
            own_q[wr_addr] <= wr_owner;
            sh_q[wr_addr]  <= wr_sharers;
        end
    end

    assign rd_state   = st_q[rd_addr];
    assign rd_owner   = own_q[rd_addr];
    assign rd_sharers = sh_q[rd_addr];

endmodule

// File: rtl/hd_sharer_pick.sv
module hd_sharer_pick #(
    parameter int NODES = 4,
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic [NODES-1:0]  pend,
    output logic [NODE_W-1:0] idx,
    output logic [NODES-1:0]  onehot
);

    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx    = NODE_W'(i);
                onehot = NODES'(1) << i;
            end
        end
    end

endmodule

// File: rtl/hd_ack_relay.sv
module hd_ack_relay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic         full_q;
    logic [W-1:0] data_q;

    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;
    assign out_data  = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (in_valid && in_ready) begin
            full_q <= 1'b1;
            data_q <= in_data;
        end else if (out_ready) begin
            full_q <= 1'b0;
        end
    end

endmodule

// File: rtl/home_dir.sv
module home_dir
    import hd_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    localparam int NODE_W = $clog2(NODES),
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_excl,
    input  logic [NODE_W-1:0] req_node,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic [NODE_W-1:0] inv_node,
    output logic [NODE_W-1:0] inv_orig,
    output logic [ADDR_W-1:0] inv_addr,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [NODE_W-1:0] fwd_owner,
    output logic [NODE_W-1:0] fwd_orig,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [NODE_W-1:0] rsp_node,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_excl,
    output logic [NODE_W-1:0] rsp_acks,
    input  logic              ack_in_valid,
    output logic              ack_in_ready,
    input  logic [NODE_W-1:0] ack_in_dest,
    input  logic [ADDR_W-1:0] ack_in_addr,
    output logic              ack_out_valid,
    input  logic              ack_out_ready,
    output logic [NODE_W-1:0] ack_out_dest,
    output logic [ADDR_W-1:0] ack_out_addr
);

    localparam int ACK_W = NODE_W + ADDR_W;

    ctl_state_e        state_q, state_d;
    logic              excl_q;
    logic [NODE_W-1:0] node_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NODES-1:0]  pend_q, pend_d;
    logic [NODE_W-1:0] cnt_q, cnt_d;
    logic [NODE_W-1:0] owner_q;

    blk_state_e        rd_state;
    logic [NODE_W-1:0] rd_owner;
    logic [NODES-1:0]  rd_sharers;
    logic              dir_we;
    blk_state_e        wr_state;
    logic [NODE_W-1:0] wr_owner;
    logic [NODES-1:0]  wr_sharers;

    logic [NODE_W-1:0] pick_idx;
    logic [NODES-1:0]  pick_onehot;
    logic [NODES-1:0]  req_bit;
    logic [NODES-1:0]  owner_bit;
    logic [NODES-1:0]  victims;
    logic              owner_hit;

    hd_dir_store #(.NODES(NODES), .BLOCKS(BLOCKS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (addr_q),
        .rd_state   (rd_state),
        .rd_owner   (rd_owner),
        .rd_sharers (rd_sharers),
        .wr_en      (dir_we),
        .wr_addr    (addr_q),
        .wr_state   (wr_state),
        .wr_owner   (wr_owner),
        .wr_sharers (wr_sharers)
    );

    hd_sharer_pick #(.NODES(NODES)) u_pick (
        .pend   (pend_q),
        .idx    (pick_idx),
        .onehot (pick_onehot)
    );

    hd_ack_relay #(.W(ACK_W)) u_relay (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ack_in_valid),
        .in_ready  (ack_in_ready),
        .in_data   ({ack_in_dest, ack_in_addr}),
        .out_valid (ack_out_valid),
        .out_ready (ack_out_ready),
        .out_data  ({ack_out_dest, ack_out_addr})
    );

    assign req_bit   = NODES'(1) << node_q;
    assign owner_bit = NODES'(1) << rd_owner;
    assign owner_hit = (rd_state == BLK_DIRTY) && (rd_owner == node_q);

    // State and transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            excl_q  <= 1'b0;
            node_q  <= '0;
            addr_q  <= '0;
            pend_q  <= '0;
            cnt_q   <= '0;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE && req_valid) begin
                excl_q <= req_excl;
                node_q <= req_node;
                addr_q <= req_addr;
            end
            if (state_q == ST_LOOKUP) begin
                owner_q <= rd_owner;
            end
        end
    end

    // Next state and directory update
    always_comb begin
        state_d    = state_q;
        pend_d     = pend_q;
        cnt_d      = cnt_q;
        dir_we     = 1'b0;
        wr_state   = rd_state;
        wr_owner   = rd_owner;
        wr_sharers = rd_sharers;
        victims    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (owner_hit) begin
                    pend_d  = '0;
                    cnt_d   = '0;
                    state_d = ST_REPLY;
                end else if (!excl_q) begin
                    dir_we   = 1'b1;
                    wr_state = BLK_SHARED;
                    pend_d   = '0;
                    cnt_d    = '0;
                    if (rd_state == BLK_DIRTY) begin
                        wr_sharers = owner_bit | req_bit;
                        state_d    = ST_FORWARD;
                    end else begin
                        wr_sharers = rd_sharers | req_bit;
                        state_d    = ST_REPLY;
                    end
                end else begin
                    if (rd_state == BLK_DIRTY)       victims = owner_bit;
                    else if (rd_state == BLK_SHARED) victims = rd_sharers & ~req_bit;
                    dir_we     = 1'b1;
                    wr_state   = BLK_DIRTY;
                    wr_owner   = node_q;
                    wr_sharers = req_bit;
                    pend_d     = victims;
                    cnt_d      = NODE_W'($countones(victims));
                    state_d    = (victims != '0) ? ST_INVAL : ST_REPLY;
                end
            end
            ST_INVAL: begin
                if (inv_ready) begin
                    pend_d = pend_q & ~pick_onehot;
                    if ((pend_q & ~pick_onehot) == '0) state_d = ST_REPLY;
                end
            end
            ST_FORWARD: begin
                if (fwd_ready) state_d = ST_REPLY;
            end
            ST_REPLY: begin
                if (rsp_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        inv_valid = (state_q == ST_INVAL);
        fwd_valid = (state_q == ST_FORWARD);
        rsp_valid = (state_q == ST_REPLY);
        inv_node  = pick_idx;
        inv_orig  = node_q;
        inv_addr  = addr_q;
        fwd_owner = owner_q;
        fwd_orig  = node_q;
        fwd_addr  = addr_q;
        rsp_node  = node_q;
        rsp_addr  = addr_q;
        rsp_excl  = excl_q;
        rsp_acks  = cnt_q;
    end

endmodule

// File: rtl/hd_chk.sv
module hd_chk #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    localparam int NODE_W = $clog2(NODES),
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              inv_valid,
    input logic              inv_ready,
    input logic [NODE_W-1:0] inv_node,
    input logic [NODE_W-1:0] inv_orig,
    input logic              fwd_valid,
    input logic [NODE_W-1:0] fwd_owner,
    input logic [NODE_W-1:0] fwd_orig,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [NODE_W-1:0] rsp_node,
    input logic [NODE_W-1:0] rsp_acks,
    input logic              ack_in_valid,
    input logic              ack_in_ready,
    input logic [NODE_W-1:0] ack_in_dest,
    input logic [ADDR_W-1:0] ack_in_addr,
    input logic              ack_out_valid,
    input logic              ack_out_ready,
    input logic [NODE_W-1:0] ack_out_dest,
    input logic [ADDR_W-1:0] ack_out_addr
);

    AST_SINGLE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inv_valid, fwd_valid, rsp_valid})); // R9

    AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid || fwd_valid || rsp_valid) |-> !req_ready); // R9

    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9

    AST_INV_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_node != inv_orig)); // R3

    AST_INV_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_ready) |=> (!inv_valid || (inv_node > $past(inv_node)))); // R3

    AST_FWD_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_owner != fwd_orig)); // R7

    AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_node) && $stable(inv_orig))); // R11

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_acks) && $stable(rsp_node))); // R11

    AST_ACK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in_valid && ack_in_ready) |=> (ack_out_valid && ack_out_dest == $past(ack_in_dest)
                                            && ack_out_addr == $past(ack_in_addr))); // R10

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out_valid && !ack_out_ready) |=> (ack_out_valid && $stable(ack_out_dest)
                                               && $stable(ack_out_addr))); // R10

endmodule

bind home_dir hd_chk #(.NODES(NODES), .BLOCKS(BLOCKS)) u_chk (.*);

// File: tb/home_dir_test.sv
`timescale 1ns/1ps
module home_dir_test;

    localparam int NN = 4;
    localparam int NB = 8;
    localparam int NW = $clog2(NN);
    localparam int AW = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_excl = 1'b0;
    logic [NW-1:0] req_node = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          inv_valid, fwd_valid, rsp_valid, rsp_excl;
    logic          inv_ready = 1'b0, fwd_ready = 1'b0, rsp_ready = 1'b0;
    logic [NW-1:0] inv_node, inv_orig, fwd_owner, fwd_orig, rsp_node, rsp_acks;
    logic [AW-1:0] inv_addr, fwd_addr, rsp_addr;
    logic          ack_in_valid = 1'b0, ack_out_ready = 1'b0;
    logic [NW-1:0] ack_in_dest = '0;
    logic [AW-1:0] ack_in_addr = '0;
    logic          ack_in_ready, ack_out_valid;
    logic [NW-1:0] ack_out_dest;
    logic [AW-1:0] ack_out_addr;

    int n_chk = 0;
    int n_bad = 0;
    int phase = 0;

    int            m_st  [NB];
    int            m_own [NB];
    logic [NN-1:0] m_sh  [NB];

    home_dir #(.NODES(NN), .BLOCKS(NB)) uut (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic do_req(input bit ex, input int n, input int a);
        int            exp_inv [NN];
        int            exp_n;
        bit            exp_fwd;
        int            exp_own;
        logic [NN-1:0] rb, vic;
        string         rq;
        int            got_inv, got_fwd;
        bit            done, rdy, hold_inv, hold_rsp;
        int            last_inv, last_acks;
        exp_n = 0; exp_fwd = 0; exp_own = 0;
        rb = NN'(1) << n;
        if (m_st[a] == 2 && m_own[a] == n) begin
            rq = "R8";
        end else if (!ex) begin
            if (m_st[a] == 2) begin
                rq = "R7"; exp_fwd = 1; exp_own = m_own[a];
                m_sh[a] = (NN'(1) << m_own[a]) | rb;
            end else begin
                rq = "R2"; m_sh[a] = m_sh[a] | rb;
            end
            m_st[a] = 1;
        end else begin
            vic = '0;
            if (m_st[a] == 2) begin rq = "R6"; vic = NN'(1) << m_own[a]; end
            else if (m_st[a] == 1) begin rq = "R3"; vic = m_sh[a] & ~rb; end
            else rq = "R5";
            for (int i = 0; i < NN; i++) if (vic[i]) begin exp_inv[exp_n] = i; exp_n++; end
            m_st[a] = 2; m_own[a] = n; m_sh[a] = rb;
        end

        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready when idle", int'(req_ready), 1);
        req_valid = 1'b1; req_excl = ex; req_node = NW'(n); req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9", "stall after accept", int'(req_ready), 0);
        got_inv = 0; got_fwd = 0; done = 0; hold_inv = 0; hold_rsp = 0;
        last_inv = 0; last_acks = 0;
        for (int c = 0; c < 60 && !done; c++) begin
            rdy = (phase % 3) != 0;
            phase++;
            inv_ready = rdy; fwd_ready = rdy; rsp_ready = rdy;
            if (hold_inv)
                chk(inv_valid && int'(inv_node) == last_inv, "R11", "inv held", int'(inv_node), last_inv);
            if (hold_rsp)
                chk(rsp_valid && int'(rsp_acks) == last_acks, "R11", "rsp held", int'(rsp_acks), last_acks);
            hold_inv = inv_valid && !rdy; last_inv = int'(inv_node);
            hold_rsp = rsp_valid && !rdy; last_acks = int'(rsp_acks);
            if (inv_valid && rdy) begin
                if (got_inv < exp_n)
                    chk(int'(inv_node) == exp_inv[got_inv], rq, "inv target", int'(inv_node), exp_inv[got_inv]);
                else
                    chk(1'b0, rq, "extra inv", got_inv + 1, exp_n);
                chk(int'(inv_orig) == n && int'(inv_addr) == a, rq, "inv orig", int'(inv_orig), n);
                got_inv++;
            end
            if (fwd_valid && rdy) begin
                got_fwd++;
                chk(int'(fwd_owner) == exp_own, rq, "fwd owner", int'(fwd_owner), exp_own);
                chk(int'(fwd_orig) == n && int'(fwd_addr) == a, rq, "fwd orig", int'(fwd_orig), n);
            end
            if (rsp_valid && rdy) begin
                done = 1;
                chk(int'(rsp_node) == n && int'(rsp_addr) == a, rq, "rsp node", int'(rsp_node), n);
                chk(rsp_excl == ex, rq, "rsp excl", int'(rsp_excl), int'(ex));
                chk(int'(rsp_acks) == exp_n, "R4", "rsp ack count", int'(rsp_acks), exp_n);
                chk(got_inv == exp_n, "R4", "invs before grant", got_inv, exp_n);
                chk(got_fwd == int'(exp_fwd), rq, "forward count", got_fwd, int'(exp_fwd));
            end
            @(negedge clk);
        end
        inv_ready = 1'b0; fwd_ready = 1'b0; rsp_ready = 1'b0;
        if (!done) chk(1'b0, "R9", "no response", 0, 1);
    endtask

    task automatic ack_test();
        int            sent, recv, guard, ld_dest, ld_addr;
        bit            orr, loaded;
        sent = 0; recv = 0; guard = 0; loaded = 0; ld_dest = 0; ld_addr = 0;
        while (recv < 40 && guard < 2000) begin
            guard++;
            @(negedge clk);
            if (loaded)
                chk(ack_out_valid && int'(ack_out_dest) == ld_dest && int'(ack_out_addr) == ld_addr,
                    "R10", "ack loaded next cycle", int'(ack_out_dest), ld_dest);
            orr = (phase % 4) != 1;
            phase++;
            ack_out_ready = orr;
            ack_in_valid  = sent < 40;
            ack_in_dest   = NW'(sent % NN);
            ack_in_addr   = AW'((sent * 3) % NB);
            #1;
            if (ack_out_valid && orr) begin
                chk(int'(ack_out_dest) == recv % NN && int'(ack_out_addr) == (recv * 3) % NB,
                    "R10", "ack order", int'(ack_out_dest), recv % NN);
                recv++;
            end
            loaded = ack_in_valid && ack_in_ready;
            if (loaded) begin
                ld_dest = sent % NN; ld_addr = (sent * 3) % NB; sent++;
            end
        end
        @(negedge clk);
        ack_in_valid = 1'b0; ack_out_ready = 1'b0;
        chk(recv == 40, "R10", "acks delivered", recv, 40);
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_own[b] = 0; m_sh[b] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(!inv_valid && !fwd_valid && !rsp_valid && !ack_out_valid, "R1", "outputs idle",
            int'({inv_valid, fwd_valid, rsp_valid, ack_out_valid}), 0);
        // first touch of every block must behave as Uncached (R1)
        for (int b = 0; b < NB; b++) do_req(b[0], b % NN, b);
        for (int s = 0; s < 512; s++) begin
            do_req(s[2], s[1:0], s % NB);
            do_req(s[5], s[4:3], s % NB);
            do_req(s[8], s[7:6], s % NB);
        end
        ack_test();
        summary();
    end

endmodule